// File: doc/BRIEF.md
# Configurable SPI Serial Port

This block is an 8-bit SPI peripheral that can serve as the bus master or as a slave. Software programs it through a small register bus made of write and read strobes. A 2-bit select-mode field picks how the slave-select pin is used:

- Three-wire point-to-point operation, where the select pin is not used.
- Four-wire operation, where the select pin is an input. A slave uses it as its chip select. A master uses it to detect a competing master.
- Four-wire master operation, where the select pin is an output whose level comes from software.

Bytes move most-significant bit first in both directions. Two control bits set the clock polarity and the clock phase.

As master, a write to the data register starts a transfer. The port generates the serial clock from the system clock through a programmable divider. As slave, the incoming serial clock, data and select are brought into the system clock domain through two-flop synchronizers. Edges are then detected on the synchronized clock. The system clock must run at least four times faster than the serial clock.

Each completed byte is copied into a receive buffer. Three sticky flags report events: transfer done, mode fault, and receive overrun.

Top module: `spi_port`

## Requirements
- R1: Registers sit at four addresses. Address 0 is control: bit0 enable, bit1 master, bit2 clock polarity (CPOL), bit3 clock phase (CPHA), bits5:4 select mode. Address 1 is the clock divider. Address 2 is data: a write loads the transmit byte, and a read returns the receive buffer. Address 3 is status: bit0 done, bit1 mode fault, bit2 overrun; writing a 1 to a status bit clears it. After reset every register reads 0 and no output enable is asserted.
- R2: As an enabled master, a data write while idle starts an 8-bit transfer. MOSI is driven from the MSB of the transmit shifter. The byte received on MISO is latched into the receive buffer. Done sets exactly 16×(divider+1) system clocks after the write edge.
- R3: As master, SCK idles at CPOL. With CPHA=0, data is sampled on the leading edge (the edge away from idle) and changes on the trailing edge. With CPHA=1, data changes on the leading edge and is sampled on the trailing edge. A slave uses the same rule.
- R4: MISO's enable is low when the port is disabled, and low for a four-wire slave (select mode 01) while NSS is high. It is always high for an enabled three-wire slave (select mode 00).
- R5: For a four-wire slave with NSS high, SCK edges are ignored. The transmit byte is kept and is shifted out unchanged at the next selected transfer.
- R6: As slave, a byte received MSB first on MOSI is latched into the receive buffer after its eighth sampling edge, and done sets. The byte previously loaded through the data register is returned on MISO.
- R7: In select mode 01 as master, a falling NSS aborts the transfer, clears the master bit, sets mode fault, and drops the SCK and MOSI enables.
- R8: In select modes 10 and 11 with the port enabled, NSS is driven as an output at the level of select-mode bit 4. In modes 00 and 01 the NSS enable is low.
- R9: If a byte completes while the receive buffer has not been read, the overrun flag sets. Reading the data register empties the buffer.
- R10: A data write during an active master transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only on data address) |
| addr | input | 2 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the current address |
| sck_i | input | 1 | Serial clock from the bus (slave) |
| sck_o | output | 1 | Serial clock to the bus (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data from the master (slave) |
| mosi_o | output | 1 | Serial data to the slave (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data from the slave (master) |
| miso_o | output | 1 | Serial data to the master (slave) |
| miso_oe | output | 1 | MISO output enable |
| nss_i | input | 1 | Slave-select input |
| nss_o | output | 1 | Slave-select output level |
| nss_oe | output | 1 | Slave-select output enable |
| done_o | output | 1 | Sticky transfer-done flag |
| modef_o | output | 1 | Sticky mode-fault flag |
| ovr_o | output | 1 | Sticky receive-overrun flag |

## Verification
Some properties are checked on every cycle:

- The master clock stays at its idle level between transfers and holds its level within each half period.
- The transmit shifter changes only on a load or a shift strobe.
- A deselected four-wire slave leaves MISO data and the receive buffer untouched.
- A select-pin fault always drops master mode and raises the fault flag.
- The last clock edge always raises done.

Other behaviour can only be shown by the bench's scenarios: MSB-first ordering, the correct sampling edge for each polarity and phase, exact transfer length per divider value, overrun sequencing, and the ignored data write during a transfer. The bench models the far end of the bus in each role and compares the bytes exchanged in both directions.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        SEL_3W      = 2'b00,
        SEL_4W_IN   = 2'b01,
        SEL_4W_OUT0 = 2'b10,
        SEL_4W_OUT1 = 2'b11
    } sel_mode_e;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_DIV  = 2'd1,
        A_DATA = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    // Control register layout, MSB first: sel[5:4], cpha[3], cpol[2], master[1], en[0]
    typedef struct packed {
        sel_mode_e sel;
        logic      cpha;
        logic      cpol;
        logic      master;
        logic      en;
    } ctrl_t;

    // Status layout: ovr[2], modef[1], done[0]
    typedef struct packed {
        logic ovr;
        logic modef;
        logic done;
    } flags_t;

    function automatic logic slave_selected(input sel_mode_e s, input logic nss);
        return (s == SEL_3W) || ((s == SEL_4W_IN) && !nss);
    endfunction

    function automatic logic nss_is_output(input sel_mode_e s);
        return (s == SEL_4W_OUT0) || (s == SEL_4W_OUT1);
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] st_q;
        always_ff @(posedge clk) begin
            if (rst) st_q <= {2{RST_VAL[i]}};
            else     st_q <= {st_q[0], d[i]};
        end
        assign q[i] = st_q[1];
    end
endmodule

// File: rtl/spi_mclk.sv
module spi_mclk #(
    parameter int DIVW = 8,
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            abort,
    input  logic [DIVW-1:0] div,
    output logic            busy,
    output logic            sck_act,
    output logic            lead,
    output logic            trail,
    output logic            last
);
    localparam int HW = $clog2(2 * BITS);
    localparam logic [HW-1:0] HC_END = HW'(2 * BITS - 1);

    logic [DIVW-1:0] pre_q;
    logic [HW-1:0]   hc_q;
    logic            busy_q;
    logic            act_q;
    logic            tick;

    assign tick    = busy_q && (pre_q == div);
    assign lead    = tick && !hc_q[0];
    assign trail   = tick &&  hc_q[0];
    assign last    = tick && (hc_q == HC_END);
    assign busy    = busy_q;
    assign sck_act = act_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy_q <= 1'b0;
            act_q  <= 1'b0;
            pre_q  <= '0;
            hc_q   <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            act_q  <= 1'b0;
            pre_q  <= '0;
            hc_q   <= '0;
        end else if (busy_q) begin
            if (tick) begin
                pre_q <= '0;
                act_q <= ~act_q;
                hc_q  <= hc_q + 1'b1;
                if (last) busy_q <= 1'b0;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R3: clock sits at its idle phase whenever no transfer runs
    a_r3_idle_phase: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !act_q);

    // R2: clock level holds for a whole half period
    a_r2_half_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick && !abort) |=> $stable(act_q));

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            sample,
    input  logic            shift,
    input  logic            bit_in,
    output logic            tx_msb,
    output logic [BITS-1:0] rx_word,
    output logic            complete,
    output logic            cnt_zero
);
    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(BITS - 1);

    logic [BITS-1:0] tx_q;
    logic [BITS-1:0] rx_q;
    logic [CW-1:0]   cnt_q;

    assign tx_msb   = tx_q[BITS-1];
    assign rx_word  = {rx_q[BITS-2:0], bit_in};
    assign complete = sample && (cnt_q == CNT_LAST);
    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
        end else if (shift) begin
            tx_q <= {tx_q[BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (sample) begin
            rx_q  <= rx_word;
            cnt_q <= complete ? '0 : cnt_q + 1'b1;
        end
    end

    // R5: transmit byte only moves on a load or shift strobe
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(tx_q));

    // R6: a cleared engine restarts its bit count
    a_r6_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIVW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          nss_i,
    output logic          nss_o,
    output logic          nss_oe,
    output logic          done_o,
    output logic          modef_o,
    output logic          ovr_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t           ctrl_q;
    logic [DIVW-1:0] div_q;
    logic [DW-1:0]   rxbuf_q;
    logic            rxf_q;
    flags_t          flg_q;
    logic            sck_d_q;
    logic            nss_d_q;

    // synchronized bus inputs, order {nss, mosi, sck}
    logic [2:0] sync_q;
    logic       sck_s, mosi_s, nss_s;

    spi_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({nss_i, mosi_i, sck_i}),
        .q   (sync_q)
    );
    assign sck_s  = sync_q[0];
    assign mosi_s = sync_q[1];
    assign nss_s  = sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d_q <= 1'b0;
            nss_d_q <= 1'b1;
        end else begin
            sck_d_q <= sck_s;
            nss_d_q <= nss_s;
        end
    end

    logic is_master, is_slave, sel_ok, slave_act;
    logic sck_chg, s_lead, s_trail, nss_fall;
    logic wr_data, rd_data, start, fault;
    logic m_busy, m_act, m_lead, m_trail, m_last;
    logic lead, trail, samp, shft;
    logic tx_msb, complete, cnt_zero, core_clear, core_load, bit_in;
    logic [DW-1:0] rx_word;

    assign is_master = ctrl_q.en && ctrl_q.master;
    assign is_slave  = ctrl_q.en && !ctrl_q.master;
    assign sel_ok    = slave_selected(ctrl_q.sel, nss_s);
    assign slave_act = is_slave && sel_ok;
    assign sck_chg   = sck_s ^ sck_d_q;
    assign s_lead    = slave_act && sck_chg && (sck_s != ctrl_q.cpol);
    assign s_trail   = slave_act && sck_chg && (sck_s == ctrl_q.cpol);
    assign nss_fall  = nss_d_q && !nss_s;

    assign wr_data = wr_en && (reg_addr_e'(addr) == A_DATA);
    assign rd_data = rd_en && (reg_addr_e'(addr) == A_DATA);
    assign start   = is_master && wr_data && !m_busy;
    assign fault   = is_master && (ctrl_q.sel == SEL_4W_IN) && nss_fall;

    spi_mclk #(.DIVW(DIVW), .BITS(DW)) i_mclk (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .abort   (fault || !is_master),
        .div     (div_q),
        .busy    (m_busy),
        .sck_act (m_act),
        .lead    (m_lead),
        .trail   (m_trail),
        .last    (m_last)
    );

    assign lead  = is_master ? m_lead  : s_lead;
    assign trail = is_master ? m_trail : s_trail;
    assign samp  = ctrl_q.cpha ? trail : lead;
    assign shft  = ctrl_q.cpha ? (lead && !cnt_zero) : trail;

    assign bit_in     = is_master ? miso_i : mosi_s;
    assign core_load  = wr_data && !(is_master && m_busy);
    assign core_clear = start || !ctrl_q.en || (is_slave && !sel_ok) || fault;

    spi_shift_core #(.BITS(DW)) i_core (
        .clk      (clk),
        .rst      (rst),
        .clear    (core_clear),
        .load     (core_load),
        .load_val (wdata),
        .sample   (samp),
        .shift    (shft),
        .bit_in   (bit_in),
        .tx_msb   (tx_msb),
        .rx_word  (rx_word),
        .complete (complete),
        .cnt_zero (cnt_zero)
    );

    // register file and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div_q   <= '0;
            rxbuf_q <= '0;
            rxf_q   <= 1'b0;
            flg_q   <= '0;
        end else begin
            if (wr_en && reg_addr_e'(addr) == A_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_en && reg_addr_e'(addr) == A_DIV)  div_q  <= wdata[DIVW-1:0];
            if (wr_en && reg_addr_e'(addr) == A_STAT) flg_q  <= flg_q & ~flags_t'(wdata[2:0]);
            if (rd_data) rxf_q <= 1'b0;
            if (complete) begin
                rxbuf_q <= rx_word;
                rxf_q   <= 1'b1;
                if (rxf_q && !rd_data) flg_q.ovr <= 1'b1;
                if (!is_master) flg_q.done <= 1'b1;
            end
            if (m_last && is_master) flg_q.done <= 1'b1;
            if (fault) begin
                ctrl_q.master <= 1'b0;
                flg_q.modef   <= 1'b1;
            end
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_CTRL:  rdata = DW'(ctrl_q);
            A_DIV:   rdata = DW'(div_q);
            A_DATA:  rdata = rxbuf_q;
            default: rdata = DW'(flg_q);
        endcase
    end

    assign sck_oe  = is_master;
    assign sck_o   = ctrl_q.cpol ^ m_act;
    assign mosi_oe = is_master;
    assign mosi_o  = tx_msb;
    assign miso_oe = slave_act;
    assign miso_o  = tx_msb;
    assign nss_oe  = ctrl_q.en && nss_is_output(ctrl_q.sel);
    assign nss_o   = ctrl_q.sel[0];
    assign done_o  = flg_q.done;
    assign modef_o = flg_q.modef;
    assign ovr_o   = flg_q.ovr;

    // R4: a disabled port never drives MISO
    a_r4_miso_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |-> !miso_oe);

    // R7: select fault drops master mode and raises the flag
    a_r7_fault_drop: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!ctrl_q.master && flg_q.modef));

    // R5: deselected four-wire slave keeps its data and buffer
    a_r5_desel_hold: assert property (@(posedge clk) disable iff (rst)
        (is_slave && ctrl_q.sel == SEL_4W_IN && nss_s && !wr_data)
        |=> ($stable(miso_o) && $stable(rxbuf_q)));

    // R2: the final clock edge raises done
    a_r2_done_on_last: assert property (@(posedge clk) disable iff (rst)
        (m_last && is_master) |=> flg_q.done);

endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, nss_i = 1'b1;
    logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, nss_o, nss_oe;
    logic done_o, modef_o, ovr_o;

    int vectors = 0;
    int miscompares = 0;

    spi_port i_spi_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .nss_i(nss_i), .nss_o(nss_o), .nss_oe(nss_oe),
        .done_o(done_o), .modef_o(modef_o), .ovr_o(ovr_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // far-end slave model for master transfers
    logic       mst_run = 1'b0;
    logic       b_cpol = 1'b0, b_cpha = 1'b0;
    logic [7:0] sb = 8'd0, rec = 8'd0;
    int         idx = 0;

    always @(sck_o) begin
        if (mst_run) begin
            if (sck_o != b_cpol) begin
                if (b_cpha) miso_i = sb[7-idx];
                else        rec = {rec[6:0], mosi_o};
            end else begin
                if (b_cpha) rec = {rec[6:0], mosi_o};
                idx++;
                if (!b_cpha && idx < 8) miso_i = sb[7-idx];
            end
        end
    end

    task automatic cfg(input int sel, input int cpha, input int cpol, input int master);
        logic [7:0] junk;
        wr(2'd0, 8'd0);
        sck_i = cpol[0]; b_cpol = cpol[0]; b_cpha = cpha[0];
        repeat (5) @(negedge clk);
        wr(2'd0, 8'((sel << 4) | (cpha << 3) | (cpol << 2) | (master << 1) | 1));
        wr(2'd3, 8'h07);
        rd(2'd2, junk);
    endtask

    task automatic half();
        repeat (8) @(negedge clk);
    endtask

    // bench acting as master toward the slave port
    task automatic slave_xfer(input logic [7:0] m, output logic [7:0] got);
        got = 8'd0;
        if (!b_cpha) mosi_i = m[7];
        half();
        for (int i = 0; i < 8; i++) begin
            sck_i = ~b_cpol;
            if (b_cpha) mosi_i = m[7-i];
            else        got = {got[6:0], miso_o};
            half();
            sck_i = b_cpol;
            if (b_cpha) got = {got[6:0], miso_o};
            else if (i < 7) mosi_i = m[6-i];
            half();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] v, got, tx;
        int dv[3] = '{0, 1, 3};
        int cnt;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl reset", v, 0);
        rd(2'd3, v); chk("R1 status reset", v, 0);
        chk("R1 oe reset", {sck_oe, mosi_oe, miso_oe, nss_oe}, 0);
        wr(2'd1, 8'd5); rd(2'd1, v); chk("R1 divider readback", v, 5);

        // R2 R3 master sweep
        for (int cp = 0; cp < 2; cp++)
            for (int ph = 0; ph < 2; ph++)
                for (int d = 0; d < 3; d++)
                    for (int k = 0; k < 4; k++) begin
                        tx = 8'((k * 73 + cp * 29 + ph * 11 + d * 5) ^ 8'hA5);
                        cfg(0, ph, cp, 1);
                        wr(2'd1, 8'(dv[d]));
                        sb = 8'((tx * 3 + 8'h3C) ^ 8'h81);
                        idx = 0; rec = 8'd0; miso_i = sb[7]; mst_run = 1'b1;
                        wr(2'd2, tx);
                        cnt = 0;
                        while (!done_o && cnt < 2000) begin
                            @(negedge clk); cnt++;
                        end
                        mst_run = 1'b0;
                        chk("R2 transfer length", cnt, 16 * (dv[d] + 1));
                        chk("R2 R3 MOSI byte", rec, tx);
                        rd(2'd2, v);
                        chk("R2 R3 MISO byte", v, sb);
                        chk("R3 SCK idle level", sck_o, cp);
                    end

        // R10 write during busy is ignored
        cfg(0, 0, 0, 1);
        wr(2'd1, 8'd3);
        sb = 8'h0F; idx = 0; rec = 8'd0; miso_i = sb[7]; mst_run = 1'b1;
        wr(2'd2, 8'hC3);
        repeat (20) @(negedge clk);
        wr(2'd2, 8'h18);
        cnt = 0;
        while (!done_o && cnt < 2000) begin @(negedge clk); cnt++; end
        mst_run = 1'b0;
        chk("R10 busy write ignored", rec, 8'hC3);
        chk("R10 single done", done_o, 1);

        // R6 R4 slave sweep, three-wire and four-wire
        for (int s = 0; s < 2; s++)
            for (int cp = 0; cp < 2; cp++)
                for (int ph = 0; ph < 2; ph++)
                    for (int k = 0; k < 3; k++) begin
                        nss_i = 1'b1;
                        cfg(s, ph, cp, 0);
                        tx = 8'((k * 91 + s * 37 + cp * 13 + ph * 7) ^ 8'h5A);
                        wr(2'd2, tx);
                        if (s == 1) begin
                            chk("R4 MISO off while deselected", miso_oe, 0);
                            nss_i = 1'b0;
                            repeat (4) @(negedge clk);
                        end
                        chk("R4 MISO driven when selected", miso_oe, 1);
                        slave_xfer(8'(tx ^ 8'hFF) + 8'(k), got);
                        nss_i = 1'b1;
                        chk("R6 slave MISO byte", got, tx);
                        chk("R6 slave done", done_o, 1);
                        rd(2'd2, v);
                        chk("R6 slave received byte", v, 8'(tx ^ 8'hFF) + 8'(k));
                    end

        // R5 deselected slave ignores SCK
        nss_i = 1'b1;
        cfg(1, 0, 0, 0);
        wr(2'd2, 8'hA5);
        slave_xfer(8'h3C, got);
        chk("R5 MISO off while deselected", miso_oe, 0);
        chk("R5 no done while deselected", done_o, 0);
        nss_i = 1'b0;
        repeat (4) @(negedge clk);
        slave_xfer(8'h96, got);
        nss_i = 1'b1;
        chk("R5 tx byte kept", got, 8'hA5);
        rd(2'd2, v); chk("R5 next byte received", v, 8'h96);

        // R9 overrun
        cfg(0, 1, 1, 0);
        slave_xfer(8'h11, got);
        chk("R9 no overrun after one byte", ovr_o, 0);
        slave_xfer(8'h22, got);
        chk("R9 overrun set", ovr_o, 1);
        rd(2'd2, v); chk("R9 buffer holds latest", v, 8'h22);
        wr(2'd3, 8'h04);
        slave_xfer(8'h33, got);
        chk("R9 no overrun after read", ovr_o, 0);

        // R7 mode fault
        nss_i = 1'b1;
        cfg(1, 0, 0, 1);
        wr(2'd1, 8'd3);
        wr(2'd2, 8'h5A);
        repeat (20) @(negedge clk);
        nss_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7 mode fault flag", modef_o, 1);
        chk("R7 SCK enable dropped", sck_oe, 0);
        chk("R7 MOSI enable dropped", mosi_oe, 0);
        rd(2'd0, v); chk("R7 master bit cleared", v[1], 0);
        repeat (100) @(negedge clk);
        chk("R7 aborted transfer no done", done_o, 0);
        nss_i = 1'b1;

        // R8 select output modes
        cfg(2, 0, 0, 1);
        chk("R8 mode 10 NSS enable", nss_oe, 1);
        chk("R8 mode 10 NSS level", nss_o, 0);
        cfg(3, 0, 0, 1);
        chk("R8 mode 11 NSS level", nss_o, 1);
        cfg(0, 0, 0, 1);
        chk("R8 mode 00 NSS enable", nss_oe, 0);
        cfg(1, 0, 0, 0);
        chk("R8 mode 01 NSS enable", nss_oe, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule